// File: doc/BRIEF.md
# Page-Buffered Flash Program Engine

This block models the write path of a byte-wide paged non-volatile memory as synchronous logic. The host issues byte-load strobes. Each strobe carries an address and a data byte. The block gathers these bytes into a page buffer. The first accepted byte opens a load window. Every further byte for the same page restarts the window. When the window runs out with no new byte, the engine commits the whole page to its storage array. During that commit every page location the host did not load is written as all-ones.

The commit is self-timed. It lasts a fixed number of clock cycles, and `busy` stays high for that time. A read issued during the commit returns a status byte instead of array contents. In that byte the top bit is the inverse of the top bit of the last loaded byte. The next bit flips on every status read. The host therefore has two ways to poll for completion. The load timeout and the commit length are parameters in clock cycles, and the array size is set by the address width.

A command decoder outside this block drives `wr_en` to qualify writes.

Top module: `page_prog_engine`

## Requirements
- R1: Address bits [ADDR_W-1:7] select the page and bits [6:0] select the byte within the 128-byte page. Bytes of one window may be loaded in any order.
- R2: Each accepted byte restarts a window of LOAD_TIMEOUT cycles. `busy` rises exactly LOAD_TIMEOUT clock edges after the edge that accepted the last byte. A byte arriving LOAD_TIMEOUT-1 edges after the previous one still joins the window.
- R3: A byte whose page differs from the page of the window's first byte is ignored. It sets `page_err`, which stays set until reset.
- R4: After the commit, every offset of the page that was not loaded in the window reads 8'hFF.
- R5: `busy` stays high for exactly PROG_CYCLES cycles. A read (`rd_stb`, `sel` and `oe` all high) returns the addressed byte on `rdata` one cycle later, and `rdata` holds its value otherwise.
- R6: Write strobes that arrive while `busy` is high are ignored. They neither change the array nor open a new window.
- R7: A byte is accepted only when `wr_stb`, `sel` and `wr_en` are high and `oe` is low. If `oe` is high, `sel` is low or `wr_en` is low, nothing is written.
- R8: A read during the commit returns a status byte: bit 7 is the inverse of bit 7 of the last accepted byte, bits 5:0 equal that byte's bits 5:0, and bit 6 alternates on each status read.
- R9: If the same offset is loaded twice in one window, the later data is the data committed.
- R10: After reset, `busy`, `page_err` and `rdata` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Byte address (page and offset) |
| wdata | input | 8 | Byte to load |
| wr_stb | input | 1 | Write strobe, one cycle per byte |
| rd_stb | input | 1 | Read strobe |
| sel | input | 1 | Chip select, active high |
| oe | input | 1 | Output enable, active high; blocks writes |
| wr_en | input | 1 | Write qualifier from the command decoder |
| rdata | output | 8 | Read data or status byte |
| busy | output | 1 | Commit in progress |
| page_err | output | 1 | Sticky flag for a byte loaded to the wrong page |

## Verification
The hardest situations to reach are the edges of the load window. One is a byte that arrives on the last cycle before the window would close, which must still extend it. The other is a strobe that arrives during the commit, which must not reopen a window. The bench handles the first by spacing loads exactly LOAD_TIMEOUT-2 idle cycles apart and then counting edges to the rise and fall of `busy`. It handles the second by issuing a write while `busy` is high and then confirming two things: the target offset still reads all-ones, and `busy` stays low afterwards.

// File: rtl/page_prog_engine.sv
module page_prog_engine #(
  parameter int ADDR_W       = 11,
  parameter int PAGE_W       = 7,
  parameter int LOAD_TIMEOUT = 8,
  parameter int PROG_CYCLES  = 160
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              wr_stb,
  input  logic              rd_stb,
  input  logic              sel,
  input  logic              oe,
  input  logic              wr_en,
  output logic [7:0]        rdata,
  output logic              busy,
  output logic              page_err
);
  localparam int PAGE_SIZE = 1 << PAGE_W;
  localparam int PN_W      = ADDR_W - PAGE_W;
  localparam int CMAX      = (LOAD_TIMEOUT > PROG_CYCLES) ? LOAD_TIMEOUT : PROG_CYCLES;
  localparam int CNT_W     = $clog2(CMAX) + 1;

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_PROG} st_t;

  st_t                  state;
  logic [7:0]           mem  [1 << ADDR_W];
  logic [7:0]           pbuf [PAGE_SIZE];
  logic [PAGE_SIZE-1:0] loaded;
  logic [PN_W-1:0]      pg;
  logic [CNT_W-1:0]     cnt;
  logic [7:0]           last;
  logic                 tog;

  wire               wr_ok   = wr_stb & sel & wr_en & ~oe;
  wire               rd_ok   = rd_stb & sel & oe;
  wire               same    = addr[ADDR_W-1:PAGE_W] == pg;
  wire [PAGE_W-1:0]  off     = addr[PAGE_W-1:0];
  wire [PAGE_W-1:0]  ci      = cnt[PAGE_W-1:0];
  wire               take    = wr_ok & ((state == S_IDLE) | ((state == S_LOAD) & same));
  wire               prog_wr = (state == S_PROG) & (cnt < CNT_W'(PAGE_SIZE));
  wire               load_end = cnt == CNT_W'(LOAD_TIMEOUT - 1);
  wire               prog_end = cnt == CNT_W'(PROG_CYCLES - 1);

  assign busy = state == S_PROG;

  always_ff @(posedge clk) begin
    if (take) pbuf[off] <= wdata;
    if (prog_wr) mem[{pg, ci}] <= loaded[ci] ? pbuf[ci] : 8'hFF;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cnt      <= '0;
      pg       <= '0;
      loaded   <= '0;
      last     <= '0;
      tog      <= 1'b0;
      page_err <= 1'b0;
      rdata    <= '0;
    end else begin
      case (state)
        S_IDLE: if (wr_ok) begin
          state  <= S_LOAD;
          cnt    <= '0;
          pg     <= addr[ADDR_W-1:PAGE_W];
          loaded <= PAGE_SIZE'(1) << off;
          last   <= wdata;
        end
        S_LOAD: if (take) begin
          cnt         <= '0;
          loaded[off] <= 1'b1;
          last        <= wdata;
        end else begin
          if (wr_ok) page_err <= 1'b1;
          if (load_end) begin
            state <= S_PROG;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        end
        S_PROG: if (prog_end) begin
          state  <= S_IDLE;
          cnt    <= '0;
          loaded <= '0;
        end else cnt <= cnt + 1'b1;
        default: state <= S_IDLE;
      endcase
      if (rd_ok) begin
        if (busy) begin
          rdata <= {~last[7], tog, last[5:0]};
          tog   <= ~tog;
        end else rdata <= mem[addr];
      end
    end
  end

  a_r3_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    page_err |=> page_err);
  a_r6_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !prog_end) |=> busy);
  a_r7_inhibit_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && wr_stb && oe) |=> state == S_IDLE);
  a_r1_page_held: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_IDLE) |=> $stable(pg));
  a_r2_prog_from_load: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(state) == S_LOAD);
endmodule

// File: tb/sim_page_prog_engine.sv
`timescale 1ns/1ps
module sim_page_prog_engine;
  localparam int AW = 11;
  localparam int LT = 8;
  localparam int PC = 140;

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic wr_stb = 0, rd_stb = 0, sel = 0, oe = 0, wr_en = 0;
  logic busy, page_err;
  int checks = 0, fails = 0;
  bit done = 0;

  page_prog_engine #(.ADDR_W(AW), .PAGE_W(7), .LOAD_TIMEOUT(LT), .PROG_CYCLES(PC)) u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_stb(wr_stb),
    .rd_stb(rd_stb), .sel(sel), .oe(oe), .wr_en(wr_en),
    .rdata(rdata), .busy(busy), .page_err(page_err));

  always #2.5 clk = ~clk;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(int a, logic [7:0] d, bit s = 1, bit we = 1, bit o = 0);
    @(negedge clk);
    addr = AW'(a); wdata = d; sel = s; wr_en = we; oe = o; wr_stb = 1;
    @(negedge clk);
    wr_stb = 0; sel = 0; wr_en = 0; oe = 0;
  endtask

  task automatic rd(int a, output logic [7:0] d);
    @(negedge clk);
    addr = AW'(a); sel = 1; oe = 1; rd_stb = 1;
    @(negedge clk);
    rd_stb = 0; sel = 0; oe = 0;
    d = rdata;
  endtask

  task automatic wait_done;
    while (!busy) @(negedge clk);
    while (busy) @(negedge clk);
    idle(1);
  endtask

  task automatic t_reset;
    check("R10 busy", busy, 0);
    check("R10 page_err", page_err, 0);
    check("R10 rdata", rdata, 0);
  endtask

  task automatic t_page_load;
    logic [7:0] d;
    wr(2*128 + 5, 8'hA5);
    idle(LT - 2);
    wr(2*128 + 1, 8'h3C);
    idle(LT - 2);
    wr(2*128 + 127, 8'h7E);
    idle(2);
    wr(2*128 + 5, 8'h5A);
    idle(LT - 1);
    check("R2 busy low before timeout", busy, 0);
    idle(1);
    check("R2 busy rises at timeout", busy, 1);
    idle(PC - 1);
    check("R5 busy still high at last cycle", busy, 1);
    idle(1);
    check("R5 busy falls after PROG_CYCLES", busy, 0);
    rd(2*128 + 5, d);   check("R9 latest data kept", d, 8'h5A);
    rd(2*128 + 1, d);   check("R1 out-of-order byte", d, 8'h3C);
    rd(2*128 + 127, d); check("R1 top offset", d, 8'h7E);
    rd(2*128 + 0, d);   check("R4 unloaded offset 0", d, 8'hFF);
    rd(2*128 + 64, d);  check("R4 unloaded offset 64", d, 8'hFF);
  endtask

  task automatic t_status_and_busy_write;
    logic [7:0] s1, s2, d;
    wr(3*128 + 20, 8'hC3);
    while (!busy) @(negedge clk);
    rd(0, s1);
    rd(0, s2);
    check("R8 status bit7 inverted", s1[7], 0);
    check("R8 status low bits", s1[5:0], 6'h03);
    check("R8 status bit6 toggles", s1[6] ^ s2[6], 1);
    wr(3*128 + 9, 8'h11);
    while (busy) @(negedge clk);
    idle(LT + 2);
    check("R6 no window after busy write", busy, 0);
    rd(3*128 + 9, d);  check("R6 busy write ignored", d, 8'hFF);
    rd(3*128 + 20, d); check("R1 page 3 byte", d, 8'hC3);
  endtask

  task automatic t_page_mismatch;
    logic [7:0] d;
    wr(4*128, 8'h12);
    wr(2*128 + 1, 8'h99);
    check("R3 page_err set", page_err, 1);
    wait_done();
    rd(4*128, d);     check("R3 window page committed", d, 8'h12);
    rd(2*128 + 1, d); check("R3 mismatched byte ignored", d, 8'h3C);
    check("R3 page_err sticky", page_err, 1);
  endtask

  task automatic t_inhibit;
    logic [7:0] d;
    wr(2*128 + 1, 8'h77, 1, 1, 1);
    wr(2*128 + 1, 8'h77, 0, 1, 0);
    wr(2*128 + 1, 8'h77, 1, 0, 0);
    idle(LT + 2);
    check("R7 no window when inhibited", busy, 0);
    rd(2*128 + 1, d); check("R7 inhibited writes ignored", d, 8'h3C);
  endtask

  initial begin
    idle(3);
    rst_n = 1;
    idle(1);
    t_reset();
    t_page_load();
    t_status_and_busy_write();
    t_page_mismatch();
    t_inhibit();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule